// File: doc/BRIEF.md
# Fine Delay and Fringe Rotator

This block sits after a streaming FFT and turns each complex frequency channel by a phase that is computed for that channel. Several channels arrive in parallel on every clock. The phase has two parts. The first is a fine-delay term that grows linearly with the channel index, which removes a residual timing offset of up to one sample clock. The second is a fringe-stop term. It is loaded from a control input and then creeps forward by one phase LSB after a programmable number of FFT frames.

The phase word covers one full turn and wraps. A pipelined CORDIC per lane turns the summed phase into cosine and sine. A complex multiplier then rotates the sample by the negative of that angle, rounds the result back to the sample width and saturates it. A sync pulse marks the clock before the first channel of a frame. The block delays that pulse along with the data, so downstream logic sees the same framing.

Top module: `fine_fringe_rotator`

## Requirements
- R1: While reset is high, and until data has flowed through, `dout` is all zeros and `sync_out` is low.
- R2: Output for any input sample is registered DW+2 clock edges after the edge that captures it. `sync_out` follows `sync_in` with the same delay, so it is high on the clock just before channel 0 of the frame leaves.
- R3: The channel index restarts at 0 on the clock after `sync_in`, regardless of where the free-running count stood. It advances by N_LANE per clock and wraps at FFT_LEN. Lane k carries index base+k.
- R4: The fine-delay phase of a channel is its index multiplied by `phase_step`, taken modulo 2^PW.
- R5: The fringe phase takes the value of `fringe_init` only on a low-to-high transition of `fringe_load`. While `fringe_load` stays high, changes on `fringe_init` are ignored.
- R6: After `sync_in`, the fringe phase increases by 1 (modulo 2^PW) each time `frames_per_step` complete frames have passed. Frame f (counting from 0) therefore uses the loaded value plus floor(f / frames_per_step).
- R7: When `frames_per_step` is 0, the fringe phase does not advance.
- R8: Each output lane equals its input times (cos θ − j·sin θ), where θ = 2π·((fine + fringe) mod 2^PW)/2^PW. The error is within a few LSB. Lane k occupies bits [k·2·DW +: 2·DW] of `din` and `dout`, with the real part in the low DW bits and the imaginary part in the high DW bits, both in two's complement.
- R9: Results outside the DW-bit signed range are clamped to the largest positive or negative value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | High on the clock before channel 0 of a frame |
| phase_step | input | PW | Fine-delay phase increment per channel |
| fringe_init | input | PW | Value loaded into the fringe phase |
| fringe_load | input | 1 | A rising edge loads `fringe_init` |
| frames_per_step | input | FCB | Frames between fringe increments; 0 freezes |
| din | input | N_LANE·2·DW | Parallel complex channels |
| sync_out | output | 1 | Delayed frame marker |
| dout | output | N_LANE·2·DW | Rotated channels |

## Verification
The hardest case to reach is a fringe increment that lands exactly at a frame boundary in a long run. The increment has to hit the first channel of the next frame, not a channel in the middle of one. It also has to wrap the phase word past 2^PW−1. The bench drives multi-frame runs with step intervals of one and three frames. One of these runs starts from a fringe value just below the wrap point. Every lane of every frame is compared against phases computed from the frame number. A separate run holds the load strobe high while changing the load value, to show that only the edge counts.

// File: rtl/frot_pkg.sv
package frot_pkg;
  // Arctangent of 2^-i expressed as a fraction of a full turn, scaled by 2^32.
  function automatic logic [31:0] atan_turn(input int i);
    case (i)
      0:  return 32'd536870912;
      1:  return 32'd316933406;
      2:  return 32'd167458907;
      3:  return 32'd85004756;
      4:  return 32'd42667331;
      5:  return 32'd21354465;
      6:  return 32'd10679838;
      7:  return 32'd5340245;
      8:  return 32'd2670163;
      9:  return 32'd1335087;
      10: return 32'd667544;
      11: return 32'd333772;
      12: return 32'd166886;
      13: return 32'd83443;
      14: return 32'd41722;
      15: return 32'd20861;
      default: return 32'd683565276 >> i;
    endcase
  endfunction
endpackage

// File: rtl/frot_phase.sv
module frot_phase #(
  parameter int N_LANE  = 2,
  parameter int FFT_LEN = 16,
  parameter int PW      = 12,
  parameter int FCB     = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sync_in,
  input  logic [PW-1:0]          phase_step,
  input  logic [PW-1:0]          fringe_init,
  input  logic                   fringe_load,
  input  logic [FCB-1:0]         frames_per_step,
  output logic [N_LANE*PW-1:0]   phase_o
);
  localparam int IW   = $clog2(FFT_LEN);
  localparam int MW   = PW + IW;
  localparam logic [IW-1:0] LAST = IW'(FFT_LEN - N_LANE);

  logic [IW-1:0]  base_q;
  logic [FCB-1:0] fcnt_q;
  logic [PW-1:0]  fringe_q;
  logic           load_d_q;
  logic           rise_c, frame_end_c, step_c;

  assign rise_c      = fringe_load & ~load_d_q;
  assign frame_end_c = !sync_in && (base_q == LAST);
  assign step_c      = frame_end_c && (frames_per_step != '0) &&
                       (FCB'(fcnt_q + 1'b1) == frames_per_step);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      fcnt_q   <= '0;
      fringe_q <= '0;
      load_d_q <= 1'b0;
    end else begin
      load_d_q <= fringe_load;
      if (sync_in || base_q == LAST) base_q <= '0;
      else                           base_q <= base_q + IW'(N_LANE);
      if (sync_in || step_c) fcnt_q <= '0;
      else if (frame_end_c)  fcnt_q <= fcnt_q + 1'b1;
      if (rise_c)      fringe_q <= fringe_init;
      else if (step_c) fringe_q <= fringe_q + 1'b1;
    end
  end

  for (genvar k = 0; k < N_LANE; k++) begin : g_lane
    logic [IW-1:0] idx_c;
    logic [MW-1:0] prod_c;
    assign idx_c  = base_q + IW'(k);
    assign prod_c = MW'(phase_step) * MW'(idx_c);
    always_ff @(posedge clk) begin
      if (rst) phase_o[k*PW +: PW] <= '0;
      else     phase_o[k*PW +: PW] <= prod_c[PW-1:0] + fringe_q;
    end
  end

  AST_BASE_RESTART: assert property (@(posedge clk) disable iff (rst)
    sync_in |=> base_q == '0); // R3
  AST_BASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!sync_in && base_q == LAST) |=> base_q == '0); // R3
  AST_FRINGE_LOAD: assert property (@(posedge clk) disable iff (rst)
    rise_c |=> fringe_q == $past(fringe_init)); // R5
  AST_FRINGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rise_c && !step_c) |=> $stable(fringe_q)); // R5
  AST_FRINGE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!rise_c && step_c) |=> fringe_q == PW'($past(fringe_q) + 1'b1)); // R6
  AST_FRINGE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!rise_c && frames_per_step == '0) |=> $stable(fringe_q)); // R7
endmodule

// File: rtl/frot_cordic.sv
module frot_cordic #(
  parameter int DW = 16,
  parameter int PW = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PW-1:0]        phase_i,
  output logic signed [DW+1:0] cos_o,
  output logic signed [DW+1:0] sin_o
);
  import frot_pkg::*;
  localparam int ITER = DW;
  localparam int CW   = DW + 2;
  localparam int ZW   = 32;
  localparam longint X0L = ((64'sd1 <<< (DW - 1)) * 64'sd39797) >>> 16;
  localparam logic signed [CW-1:0] X0 = CW'(X0L);
  localparam int CMAX = (1 << (DW - 1)) + 64;

  logic signed [CW-1:0] xs [ITER+1];
  logic signed [CW-1:0] ys [ITER+1];
  logic signed [ZW-1:0] zs [ITER+1];
  logic [1:0]           qs [ITER+1];

  assign xs[0] = X0;
  assign ys[0] = '0;
  assign zs[0] = {2'b00, phase_i[PW-3:0], {(ZW-PW){1'b0}}};
  assign qs[0] = phase_i[PW-1:PW-2];

  for (genvar i = 0; i < ITER; i++) begin : g_stage
    localparam logic signed [ZW-1:0] ANG = signed'(atan_turn(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        xs[i+1] <= '0; ys[i+1] <= '0; zs[i+1] <= '0; qs[i+1] <= '0;
      end else begin
        qs[i+1] <= qs[i];
        if (zs[i][ZW-1]) begin
          xs[i+1] <= xs[i] + (ys[i] >>> i);
          ys[i+1] <= ys[i] - (xs[i] >>> i);
          zs[i+1] <= zs[i] + ANG;
        end else begin
          xs[i+1] <= xs[i] - (ys[i] >>> i);
          ys[i+1] <= ys[i] + (xs[i] >>> i);
          zs[i+1] <= zs[i] - ANG;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cos_o <= '0; sin_o <= '0;
    end else begin
      case (qs[ITER])
        2'd0: begin cos_o <= xs[ITER];  sin_o <= ys[ITER];  end
        2'd1: begin cos_o <= -ys[ITER]; sin_o <= xs[ITER];  end
        2'd2: begin cos_o <= -xs[ITER]; sin_o <= -ys[ITER]; end
        default: begin cos_o <= ys[ITER]; sin_o <= -xs[ITER]; end
      endcase
    end
  end

  AST_COEF_BOUND: assert property (@(posedge clk) disable iff (rst)
    (cos_o <= CMAX) && (cos_o >= -CMAX) && (sin_o <= CMAX) && (sin_o >= -CMAX)); // R8
endmodule

// File: rtl/frot_cmul.sv
module frot_cmul #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] re_i,
  input  logic signed [DW-1:0] im_i,
  input  logic signed [DW+1:0] cos_i,
  input  logic signed [DW+1:0] sin_i,
  output logic signed [DW-1:0] re_o,
  output logic signed [DW-1:0] im_o
);
  localparam int CW = DW + 2;
  localparam int AW = DW + CW + 1;
  localparam logic signed [AW-1:0] RND  = AW'(1) <<< (DW - 2);
  localparam logic signed [AW-1:0] MAXV = (AW'(1) <<< (DW - 1)) - 1;
  localparam logic signed [AW-1:0] MINV = -(AW'(1) <<< (DW - 1));

  logic signed [AW-1:0] xr, xi, c, s, acc_re, acc_im, sh_re, sh_im;

  assign xr = AW'(re_i);
  assign xi = AW'(im_i);
  assign c  = AW'(cos_i);
  assign s  = AW'(sin_i);
  assign acc_re = xr * c + xi * s;
  assign acc_im = xi * c - xr * s;
  assign sh_re  = (acc_re + RND) >>> (DW - 1);
  assign sh_im  = (acc_im + RND) >>> (DW - 1);

  function automatic logic signed [DW-1:0] clamp(input logic signed [AW-1:0] v);
    if (v > MAXV)      return MAXV[DW-1:0];
    else if (v < MINV) return MINV[DW-1:0];
    else               return v[DW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      re_o <= '0; im_o <= '0;
    end else begin
      re_o <= clamp(sh_re);
      im_o <= clamp(sh_im);
    end
  end
endmodule

// File: rtl/fine_fringe_rotator.sv
module fine_fringe_rotator #(
  parameter int N_LANE  = 2,
  parameter int FFT_LEN = 16,
  parameter int DW      = 16,
  parameter int PW      = 12,
  parameter int FCB     = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sync_in,
  input  logic [PW-1:0]            phase_step,
  input  logic [PW-1:0]            fringe_init,
  input  logic                     fringe_load,
  input  logic [FCB-1:0]           frames_per_step,
  input  logic [N_LANE*2*DW-1:0]   din,
  output logic                     sync_out,
  output logic [N_LANE*2*DW-1:0]   dout
);
  localparam int ITER   = DW;
  localparam int DDLY   = ITER + 2;
  localparam int SDLY   = ITER + 3;
  localparam int BUS_W  = N_LANE * 2 * DW;

  logic [N_LANE*PW-1:0] phase_w;
  logic [BUS_W-1:0]     dpipe [DDLY];
  logic [SDLY-1:0]      spipe;

  frot_phase #(.N_LANE(N_LANE), .FFT_LEN(FFT_LEN), .PW(PW), .FCB(FCB)) u_phase (
    .clk(clk), .rst(rst), .sync_in(sync_in), .phase_step(phase_step),
    .fringe_init(fringe_init), .fringe_load(fringe_load),
    .frames_per_step(frames_per_step), .phase_o(phase_w));

  always_ff @(posedge clk) begin
    if (rst) begin
      spipe <= '0;
      for (int j = 0; j < DDLY; j++) dpipe[j] <= '0;
    end else begin
      spipe <= {spipe[SDLY-2:0], sync_in};
      dpipe[0] <= din;
      for (int j = 1; j < DDLY; j++) dpipe[j] <= dpipe[j-1];
    end
  end
  assign sync_out = spipe[SDLY-1];

  for (genvar k = 0; k < N_LANE; k++) begin : g_lane
    logic signed [DW+1:0] cos_w, sin_w;
    logic signed [DW-1:0] re_w, im_w;
    frot_cordic #(.DW(DW), .PW(PW)) u_cordic (
      .clk(clk), .rst(rst), .phase_i(phase_w[k*PW +: PW]),
      .cos_o(cos_w), .sin_o(sin_w));
    frot_cmul #(.DW(DW)) u_cmul (
      .clk(clk), .rst(rst),
      .re_i(dpipe[DDLY-1][k*2*DW +: DW]),
      .im_i(dpipe[DDLY-1][k*2*DW+DW +: DW]),
      .cos_i(cos_w), .sin_i(sin_w), .re_o(re_w), .im_o(im_w));
    assign dout[k*2*DW +: 2*DW] = {im_w, re_w};
  end

  AST_SYNC_OUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (spipe[SDLY-2] == 1'b0) |=> !sync_out); // R2
endmodule

// File: tb/fine_fringe_rotator_tb_top.sv
module fine_fringe_rotator_tb_top;
  localparam int N = 2, FL = 16, DW = 16, PW = 12, FCB = 4;
  localparam int CPF = FL / N, TOL = 12, PMOD = 1 << PW;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0, rst = 1'b1, sync_in = 1'b0, fringe_load = 1'b0;
  logic [PW-1:0] phase_step = '0, fringe_init = '0;
  logic [FCB-1:0] frames_per_step = '0;
  logic [N*2*DW-1:0] din = '0;
  logic sync_out;
  logic [N*2*DW-1:0] dout;

  int errors = 0, checks = 0, cyc = 0, exp_sync_cyc = -1;
  bit active = 0;
  int q_re[$], q_im[$];
  string q_tag[$];

  fine_fringe_rotator #(.N_LANE(N), .FFT_LEN(FL), .DW(DW), .PW(PW), .FCB(FCB)) dut_i (
    .clk(clk), .rst(rst), .sync_in(sync_in), .phase_step(phase_step),
    .fringe_init(fringe_init), .fringe_load(fringe_load),
    .frames_per_step(frames_per_step), .din(din), .sync_out(sync_out), .dout(dout));

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic int clip(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // monitor: compare popped expectations, then arm on sync_out
  always @(negedge clk) begin
    if (active && q_re.size() > 0) begin
      for (int k = 0; k < N; k++) begin
        int er, ei, ar, ai;
        string t;
        er = q_re.pop_front(); ei = q_im.pop_front(); t = q_tag.pop_front();
        ar = $signed(dout[k*2*DW +: DW]);
        ai = $signed(dout[k*2*DW+DW +: DW]);
        checks++;
        if ((ar - er > TOL) || (er - ar > TOL) || (ai - ei > TOL) || (ei - ai > TOL)) begin
          errors++;
          $display("FAIL %s lane %0d: actual (%0d,%0d) expected (%0d,%0d)", t, k, ar, ai, er, ei);
        end
      end
      if (q_re.size() == 0) active = 0;
    end
    if (sync_out && !rst) begin
      checks++;
      if (cyc != exp_sync_cyc) begin
        errors++;
        $display("FAIL R2 sync_out timing: actual cycle %0d expected %0d", cyc, exp_sync_cyc);
      end
      active = 1;
    end
  end

  task automatic load_fringe(int v, bit change_held, int v2);
    @(posedge clk); #1 fringe_load = 1'b0; frames_per_step = '0;
    repeat (2) @(posedge clk);
    #1 fringe_init = PW'(v); fringe_load = 1'b1;
    repeat (2) @(posedge clk);
    #1 if (change_held) fringe_init = PW'(v2);
    repeat (3) @(posedge clk);
  endtask

  task automatic run(string tag, int tf, int f0, int fs, int nfr, bit sat_mode, int seed);
    @(posedge clk); #1
    phase_step = PW'(tf); sync_in = 1'b1; frames_per_step = FCB'(fs);
    exp_sync_cyc = cyc + 1 + DW + 2;
    for (int c = 0; c < nfr * CPF; c++) begin
      @(posedge clk); #1 sync_in = 1'b0;
      for (int k = 0; k < N; k++) begin
        int xr, xi, idx, fr, ph;
        real a, er, ei;
        if (sat_mode) begin
          xr = (k == 0) ? 32767 : -32768; xi = xr;
        end else begin
          xr = ((c * 1237 + k * 4111 + seed) % 40001) - 20000;
          xi = ((c * 2903 + k * 577 + seed * 3) % 40001) - 20000;
        end
        din[k*2*DW +: DW] = DW'(xr);
        din[k*2*DW+DW +: DW] = DW'(xi);
        idx = (c % CPF) * N + k;
        fr = f0 + ((fs == 0) ? 0 : (c / CPF) / fs);
        ph = (idx * tf + fr) % PMOD;
        a = TWO_PI * ph / PMOD;
        er = xr * $cos(a) + xi * $sin(a);
        ei = xi * $cos(a) - xr * $sin(a);
        q_re.push_back(clip(int'(er)));
        q_im.push_back(clip(int'(ei)));
        q_tag.push_back(tag);
      end
    end
    @(posedge clk); #1 din = '0; frames_per_step = '0;
    repeat (DW + 8) @(posedge clk);
    checks++;
    if (q_re.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d results missing, expected 0", tag, q_re.size());
    end
    q_re.delete(); q_im.delete(); q_tag.delete(); active = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    checks++;
    if (dout !== '0 || sync_out !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual dout=%h sync_out=%b expected 0/0", dout, sync_out);
    end
    @(posedge clk); #1 rst = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (dout !== '0 || sync_out !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset: actual dout=%h sync_out=%b expected 0/0", dout, sync_out);
    end
    // R8 identity rotation
    load_fringe(0, 0, 0);
    run("R8", 0, 0, 0, 2, 0, 11);
    // R4 fine-delay ramp
    load_fringe(100, 0, 0);
    run("R4", 37, 100, 0, 3, 0, 22);
    // R6 fringe steps every third frame
    load_fringe(2000, 0, 0);
    run("R6", 5, 2000, 3, 8, 0, 33);
    // R3 sync at an arbitrary index, step every frame, fringe wraps (R6)
    load_fringe(4094, 0, 0);
    repeat (3) @(posedge clk);
    run("R3/R6", 301, 4094, 1, 4, 0, 44);
    // R5 held load ignores new value, R7 frozen fringe
    load_fringe(3000, 1, 500);
    run("R5/R7", 11, 3000, 0, 6, 0, 55);
    // R9 saturation at 45 degrees
    load_fringe(512, 0, 0);
    run("R9", 0, 512, 0, 1, 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule